// File: doc/BRIEF.md
# Addressed SPI Register Slave

This block is the serial front end of an 8-bit port expander. It listens on a four-wire SPI link in mode 0 and turns each chip-select frame into accesses on a simple parallel register bus. The register file, the interrupt logic and the pin drivers sit behind that bus. Up to eight expanders can share one chip select, because every frame begins with a command byte that names the target device.

A frame has three parts. The command byte holds a fixed prefix, a 3-bit device number and a read/write flag. The next byte is the register index. Every byte after that is data. Writes reach the bus as one-cycle strobes. Reads are fetched from the bus and shifted out on MISO. Two static configuration inputs control the decoding. One turns device-number matching on or off. The other stops the register index from stepping between data bytes. All SPI pins are resynchronised into the system clock domain, and the block samples SCK there.

Top module: `gxs_spi_regslave`

## Requirements
- R1: A frame is accepted only if its first byte has 4'b0100 in bits 7:4 and the expected device number in bits 3:1. Bit 0 selects a read when 1 and a write when 0. A frame with any other prefix causes no bus strobe and never drives MISO.
- R2: When `cfg_addr_match_en` is 1, the expected device number is `cfg_hw_addr`. A frame that carries another number is ignored: no strobe and no MISO drive.
- R3: When `cfg_addr_match_en` is 0, the expected device number is 3'b000 whatever `cfg_hw_addr` holds.
- R4: In an accepted write frame, the second byte loads the register index. Each later complete byte raises `reg_wr` for exactly one clock, with `reg_addr` set to the current index and `reg_wdata` set to the byte.
- R5: When `cfg_seq_disable` is 0, the index advances by one after each data byte and wraps from 8'hFF to 8'h00.
- R6: When `cfg_seq_disable` is 1, every data byte of a frame uses the index given in the second byte.
- R7: In an accepted read frame, `reg_rd` is high for one clock per data byte, and `reg_rdata` is taken in that same clock. The byte leaves on MISO MSB first. Its first bit is valid before the first SCK rising edge of that data byte. The master samples MISO on each SCK rising edge.
- R8: `spi_miso_oe` is 1 only from the end of the index byte to the end of the frame, and only in an accepted read frame. Otherwise it is 0.
- R9: Raising `spi_cs_n` drops any partial byte without a strobe. The next frame is decoded from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select shared by all devices on the link |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad buffer |
| cfg_hw_addr | input | 3 | Strapped device number |
| cfg_addr_match_en | input | 1 | 1: compare the device number with `cfg_hw_addr`; 0: compare it with zero |
| cfg_seq_disable | input | 1 | 1: keep the register index fixed within a frame |
| reg_addr | output | 8 | Register index for the current bus access |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the clock where `reg_rd` is high |

## Verification
The assertions assume that SCK stays high and low for at least four system clocks each. This keeps strobes at least a byte apart and makes "exactly one clock" observable. They also assume that the configuration inputs do not change while a frame is in progress. The bench keeps inside these limits. Its master model holds each SCK phase for eight clocks, changes MOSI only while SCK is low, and changes the configuration only between frames, with chip select high. The register file in the bench answers reads in the same clock as `reg_rd`, which is the read-data timing this block expects.

// File: rtl/gxs_pkg.sv
`timescale 1ns/1ps
package gxs_pkg;
    localparam int BYTE_W = 8;
    localparam int DEV_W  = 3;
    localparam int PFX_W  = BYTE_W - DEV_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_IDX  = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    bit_cnt;
        logic [BYTE_W-2:0]   rx_sh;
        logic [BYTE_W-1:0]   tx_sh;
        logic                is_rd;
        logic [BYTE_W-1:0]   ptr;
        logic [BYTE_W-1:0]   bus_addr;
        logic [BYTE_W-1:0]   wdata;
        logic                wr;
        logic                rd;
        logic                oe;
    } slv_state_t;
endpackage

// File: rtl/gxs_sync.sv
`timescale 1ns/1ps
module gxs_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gxs_edge.sv
`timescale 1ns/1ps
module gxs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_q;
    logic prev_d;

    always_comb prev_d = sig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/gxs_spi_regslave.sv
`timescale 1ns/1ps
module gxs_spi_regslave
    import gxs_pkg::*;
#(
    parameter logic [PFX_W-1:0] CMD_PREFIX = 4'b0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [DEV_W-1:0]  cfg_hw_addr,
    input  logic              cfg_addr_match_en,
    input  logic              cfg_seq_disable,
    output logic [BYTE_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    // Synchronised pins: {cs_n, sck, mosi}; chip select resets inactive
    logic [2:0] pins_s;
    logic       cs_s;
    logic       sck_s;
    logic       mosi_s;
    logic       sck_rise;
    logic       sck_fall;

    gxs_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sck, spi_mosi}),
        .q     (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[0];

    gxs_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (sck_s),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    slv_state_t s_q;
    slv_state_t s_d;

    logic [BYTE_W-1:0] byte_in;
    logic [DEV_W-1:0]  dev_sel;
    logic [BYTE_W-1:0] step;
    logic              cmd_hit;

    always_comb begin
        byte_in = {s_q.rx_sh, mosi_s};
        dev_sel = cfg_addr_match_en ? cfg_hw_addr : '0;
        step    = {{(BYTE_W-1){1'b0}}, ~cfg_seq_disable};
        cmd_hit = (byte_in[BYTE_W-1 -: PFX_W] == CMD_PREFIX) &&
                  (byte_in[DEV_W:1] == dev_sel);

        s_d    = s_q;
        s_d.wr = 1'b0;
        s_d.rd = 1'b0;

        if (cs_s) begin
            s_d.phase   = PH_CMD;
            s_d.bit_cnt = '0;
            s_d.oe      = 1'b0;
        end else begin
            if (sck_rise) begin
                s_d.rx_sh   = byte_in[BYTE_W-2:0];
                s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                if (s_q.bit_cnt == LAST_BIT) begin
                    unique case (s_q.phase)
                        PH_CMD: begin
                            if (cmd_hit) begin
                                s_d.phase = PH_IDX;
                                s_d.is_rd = byte_in[0];
                            end else begin
                                s_d.phase = PH_SKIP;
                            end
                        end
                        PH_IDX: begin
                            s_d.phase    = PH_DATA;
                            s_d.ptr      = byte_in;
                            s_d.bus_addr = byte_in;
                            if (s_q.is_rd) begin
                                s_d.rd = 1'b1;
                                s_d.oe = 1'b1;
                            end
                        end
                        PH_DATA: begin
                            s_d.ptr = s_q.ptr + step;
                            if (s_q.is_rd) begin
                                s_d.bus_addr = s_q.ptr + step;
                                s_d.rd       = 1'b1;
                            end else begin
                                s_d.bus_addr = s_q.ptr;
                                s_d.wdata    = byte_in;
                                s_d.wr       = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            // Mode 0: advance MISO on falling edges inside a byte only
            if (sck_fall && s_q.phase == PH_DATA && s_q.is_rd &&
                s_q.bit_cnt != '0) begin
                s_d.tx_sh = s_q.tx_sh << 1;
            end
            if (s_q.rd) begin
                s_d.tx_sh = reg_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_CMD;
        end else begin
            s_q <= s_d;
        end
    end

    assign spi_miso    = s_q.oe & s_q.tx_sh[BYTE_W-1];
    assign spi_miso_oe = s_q.oe;
    assign reg_addr    = s_q.bus_addr;
    assign reg_wr      = s_q.wr;
    assign reg_wdata   = s_q.wdata;
    assign reg_rd      = s_q.rd;
endmodule

// File: rtl/gxs_spi_regslave_chk.sv
`timescale 1ns/1ps
module gxs_spi_regslave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic reg_wr,
    input logic reg_rd,
    input logic spi_miso_oe
);
    // R4: write strobe lasts one clock
    a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R4 / R7: bus never reads and writes in the same clock
    a_r4_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R7: read strobe lasts one clock
    a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R7: MISO drive starts together with the first read fetch
    a_r7_oe_with_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> reg_rd);

    // R8: write frames never drive MISO
    a_r8_no_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !spi_miso_oe);

    // R8: released chip select turns the driver off
    a_r8_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_miso_oe);

    // R9: no write strobe follows a released chip select
    a_r9_no_wr_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !reg_wr);
endmodule

bind gxs_spi_regslave gxs_spi_regslave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .spi_miso_oe (spi_miso_oe)
);

// File: tb/gxs_spi_regslave_tb.sv
`timescale 1ns/1ps
module gxs_spi_regslave_tb;
    localparam int HALF  = 8;
    localparam int LIMIT = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       spi_miso_oe;
    logic [2:0] cfg_hw_addr = 3'd5;
    logic       cfg_addr_match_en = 1'b1;
    logic       cfg_seq_disable = 1'b0;
    logic [7:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic       reg_rd;
    logic [7:0] reg_rdata;

    always #10 clk = ~clk;

    gxs_spi_regslave u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .spi_sck           (spi_sck),
        .spi_cs_n          (spi_cs_n),
        .spi_mosi          (spi_mosi),
        .spi_miso          (spi_miso),
        .spi_miso_oe       (spi_miso_oe),
        .cfg_hw_addr       (cfg_hw_addr),
        .cfg_addr_match_en (cfg_addr_match_en),
        .cfg_seq_disable   (cfg_seq_disable),
        .reg_addr          (reg_addr),
        .reg_wr            (reg_wr),
        .reg_wdata         (reg_wdata),
        .reg_rd            (reg_rd),
        .reg_rdata         (reg_rdata)
    );

    // Register file seen by the block, and the bench's own expected copy
    logic [7:0]  mem     [256];
    logic [7:0]  exp_mem [256];
    logic [7:0]  wbuf    [8];
    logic [15:0] wq [$];
    int vec  = 0;
    int miss = 0;
    bit done = 1'b0;

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Every write strobe must match the next predicted write
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            if (wq.size() == 0) begin
                vec++;
                miss++;
                $display("FAIL R2 unexpected write: actual %h expected none", {reg_addr, reg_wdata});
            end else begin
                check("R4 write strobe", {reg_addr, reg_wdata}, wq.pop_front());
            end
        end
    end

    task automatic xfer(input logic [7:0] tx, input bit exp_oe, input logic [7:0] exp_rx, input string req);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = tx[b];
            repeat (HALF) @(negedge clk);
            check({req, " R8 oe"}, 16'(spi_miso_oe), 16'(exp_oe));
            if (exp_oe) check({req, " R7 miso"}, 16'(spi_miso), 16'(exp_rx[b]));
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic close_frame(input string req);
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
        check({req, " pending writes"}, 16'(wq.size()), 16'd0);
        check({req, " R8 oe idle"}, 16'(spi_miso_oe), 16'd0);
    endtask

    task automatic frame(input logic [7:0] cmd, input logic [7:0] idx, input int n, input string req);
        bit sel;
        logic [7:0] p;
        logic [7:0] d;
        sel = (cmd[7:4] == 4'h4) &&
              (cmd[3:1] == (cfg_addr_match_en ? cfg_hw_addr : 3'd0));
        p = idx;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        xfer(cmd, 1'b0, 8'h00, req);
        xfer(idx, 1'b0, 8'h00, req);
        for (int i = 0; i < n; i++) begin
            if (cmd[0]) begin
                d = exp_mem[p];
                xfer(8'h00, sel, d, req);
            end else begin
                d = wbuf[i];
                if (sel) begin
                    wq.push_back({p, d});
                    exp_mem[p] = d;
                end
                xfer(d, 1'b0, 8'h00, req);
            end
            if (!cfg_seq_disable) p = p + 8'd1;
        end
        close_frame(req);
    endtask

    task automatic partial(input logic [7:0] b0, input logic [7:0] b1, input int full, input int nbits, input string req);
        logic [7:0] bytes [2];
        bytes[0] = b0;
        bytes[1] = b1;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < full; i++) xfer(bytes[i], 1'b0, 8'h00, req);
        for (int b = 0; b < nbits; b++) begin
            spi_mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        close_frame(req);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            vec++;
            miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // Reset state
        check("R8 reset oe", 16'(spi_miso_oe), 16'd0);
        check("R4 reset strobes", {14'd0, reg_wr, reg_rd}, 16'd0);

        // R1 R4 R5: burst write with matching device number 5
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h7E;
        frame(8'h4A, 8'h10, 3, "R1 R4 R5 burst write");
        // R7 R5: burst read back
        frame(8'h4B, 8'h10, 3, "R7 R5 burst read");
        // R2: other device number, write then read
        wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
        frame(8'h44, 8'h10, 2, "R2 foreign write");
        frame(8'h45, 8'h10, 2, "R2 foreign read");
        frame(8'h4B, 8'h10, 2, "R2 contents kept");
        // R1: wrong prefix
        wbuf[0] = 8'h01;
        frame(8'hCA, 8'h11, 1, "R1 bad prefix");
        frame(8'h4B, 8'h11, 1, "R1 contents kept");
        // R6: fixed index
        cfg_seq_disable = 1'b1;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        frame(8'h4A, 8'h20, 2, "R6 fixed write");
        frame(8'h4B, 8'h20, 3, "R6 fixed read");
        frame(8'h4B, 8'h21, 1, "R6 neighbour kept");
        cfg_seq_disable = 1'b0;
        // R5: wrap past the top index
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
        frame(8'h4A, 8'hFE, 3, "R5 wrap write");
        frame(8'h4B, 8'hFE, 3, "R5 wrap read");
        // R3: matching off, device number treated as zero
        cfg_addr_match_en = 1'b0;
        wbuf[0] = 8'h66;
        frame(8'h4A, 8'h30, 1, "R3 strap ignored");
        wbuf[0] = 8'h99;
        frame(8'h40, 8'h30, 1, "R3 zero write");
        frame(8'h41, 8'h30, 1, "R3 zero read");
        cfg_addr_match_en = 1'b1;
        // R9: aborts in the data byte and in the command byte
        partial(8'h4A, 8'h50, 2, 4, "R9 abort data");
        partial(8'h4A, 8'h00, 0, 3, "R9 abort command");
        frame(8'h4B, 8'h50, 1, "R9 contents kept");
        wbuf[0] = 8'h55;
        frame(8'h4A, 8'h51, 1, "R9 next frame write");
        frame(8'h4B, 8'h51, 1, "R9 next frame read");

        done = 1'b1;
        finish_run();
    end
endmodule